// File: doc/BRIEF.md
# Configuration Address Decoder and Bridge Router

This block sits behind a memory-mapped host port. It takes each accepted request and routes it to exactly one target. If the address falls in the configuration window, it splits the address into bus, device, function and register-dword fields. The request then goes to one of three places: a local device on the primary bus, the bridge's secondary bus as a type-0 access, or through the bridge unchanged as a type-1 access. Any other address is treated as a memory transaction. The bridge forwards it only when the bridge's command enables allow it and the address lies inside one of the two programmed forwarding windows.

The bridge register values come in as inputs. The block decides the route in the accept cycle. It registers that decision, and in the next cycle it raises a one-cycle select strobe and a one-cycle response. A request that reaches no target raises a one-cycle miss flag. A read that misses returns all ones, so an absent device reads as vendor 0xFFFF.

Top module: `cfg_route_top`

## Requirements
- R1: An address is a configuration access when bits 31:28 equal 0x3. Any other address is a memory transaction. For a configuration access, the field outputs give bus = bits 27:20, device = bits 19:15, function = bits 14:12 and register dword index = bits 11:2.
- R2: A configuration access is routed locally when all of these hold: its bus equals the primary bus number, its function is 0, its device is below NUM_LOCAL, and the matching bit of loc_present_i is set. In that case only bit [device] of loc_sel_o pulses, in the cycle after acceptance. Any other access on the primary bus is a miss.
- R3: When the bridge is programmed, a configuration access whose bus equals the secondary bus number raises fwd_t0_o.
- R4: When the bridge is programmed, a configuration access whose bus is above the secondary number and at or below the subordinate number raises fwd_t1_o.
- R5: The bridge counts as programmed only when secondary > primary and subordinate >= secondary. When it is not programmed, an access to a bus other than the primary bus is a miss.
- R6: A memory transaction matches a window when addr[31:20] lies between base[15:4] and limit[15:4], inclusive at both ends. Either the memory window or the prefetchable window may match. Bits 3:0 of base and limit are ignored, so the granularity is 1 MiB.
- R7: A memory transaction is forwarded (mem_fwd_o) only when command bit 1 and command bit 2 are both set. Otherwise it is a miss.
- R8: A request that reaches no target raises miss_o for exactly one cycle. If that request is a read, rsp_rdata_o is 0xFFFF_FFFF.
- R9: Each accepted request gives rsp_valid_o for one cycle, in the cycle after acceptance. Exactly one route output is high in that cycle. A read that hits returns tgt_rdata_i, and a write returns zero data.
- R10: While rst_ni is low, req_ready_o and every strobe and response output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | 32 | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| brg_cmd_i | input | 16 | Bridge command register |
| brg_pri_bus_i | input | 8 | Bridge primary bus number |
| brg_sec_bus_i | input | 8 | Bridge secondary bus number |
| brg_sub_bus_i | input | 8 | Bridge subordinate bus number |
| brg_mem_base_i | input | 16 | Memory window base, address bits 31:16 |
| brg_mem_limit_i | input | 16 | Memory window limit, address bits 31:16 |
| brg_pf_base_i | input | 16 | Prefetchable window base, address bits 31:16 |
| brg_pf_limit_i | input | 16 | Prefetchable window limit, address bits 31:16 |
| loc_present_i | input | NUM_LOCAL | Presence of each local device on the primary bus |
| tgt_rdata_i | input | 32 | Read data from the selected target |
| loc_sel_o | output | NUM_LOCAL | One-hot local device select strobe |
| fwd_t0_o | output | 1 | Forward as type-0 to the secondary bus |
| fwd_t1_o | output | 1 | Forward unchanged as type-1 |
| mem_fwd_o | output | 1 | Memory transaction forwarded through the bridge |
| miss_o | output | 1 | No target matched |
| cfg_bus_o | output | 8 | Decoded bus number |
| cfg_dev_o | output | 5 | Decoded device number |
| cfg_fn_o | output | 3 | Decoded function number |
| cfg_reg_o | output | 10 | Decoded register dword index |
| tgt_addr_o | output | 32 | Registered request address |
| tgt_write_o | output | 1 | Registered write flag |
| tgt_wdata_o | output | 32 | Registered write data |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_rdata_o | output | 32 | Response read data |

## Verification
The assertions compare registered route outputs with the bridge and presence inputs from the accept cycle. They therefore assume that these register values do not change between acceptance and the following cycle. The bench changes the bridge setup only between requests, with idle cycles in between. The assertions also assume that tgt_rdata_i is valid whenever a hit read is responded. The bench holds tgt_rdata_i at a fixed pattern throughout.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 10;

  typedef enum logic [2:0] {
    RT_NONE, RT_LOCAL, RT_T0, RT_T1, RT_MEM, RT_MISS
  } route_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] reg_idx;
  } cfg_fields_t;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_route_pkg::*;
#(
  parameter logic [3:0] CFG_NIB = 4'h3
) (
  input  logic [31:0]  addr_i,
  output logic         is_cfg_o,
  output cfg_fields_t  fields_o
);
  assign is_cfg_o         = (addr_i[31:28] == CFG_NIB);
  assign fields_o.bus     = addr_i[27:20];
  assign fields_o.dev     = addr_i[19:15];
  assign fields_o.fn      = addr_i[14:12];
  assign fields_o.reg_idx = addr_i[11:2];
endmodule

// File: rtl/bus_range_check.sv
module bus_range_check #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] bus_i,
  input  logic [BW-1:0] pri_i,
  input  logic [BW-1:0] sec_i,
  input  logic [BW-1:0] sub_i,
  output logic          is_pri_o,
  output logic          brg_ok_o,
  output logic          is_sec_o,
  output logic          below_o
);
  // bridge is usable only once numbered above its primary side
  assign brg_ok_o = (sec_i > pri_i) && (sub_i >= sec_i);
  assign is_pri_o = (bus_i == pri_i);
  assign is_sec_o = (bus_i == sec_i);
  assign below_o  = (bus_i > sec_i) && (bus_i <= sub_i);
endmodule

// File: rtl/mem_window_check.sv
module mem_window_check #(
  parameter int CMP_LSB = 20
) (
  input  logic [31:0] addr_i,
  input  logic [15:0] base_i,
  input  logic [15:0] limit_i,
  output logic        hit_o
);
  localparam int CW     = 32 - CMP_LSB;
  localparam int REG_LO = 16 - CW;

  logic [CW-1:0] a_s, b_s, l_s;
  assign a_s   = addr_i[31:CMP_LSB];
  assign b_s   = base_i[15:REG_LO];
  assign l_s   = limit_i[15:REG_LO];
  assign hit_o = (a_s >= b_s) && (a_s <= l_s);
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
#(
  parameter int         NUM_LOCAL = 4,
  parameter logic [3:0] CFG_NIB   = 4'h3,
  parameter int         CMP_LSB   = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [31:0]          req_addr_i,
  input  logic                 req_write_i,
  input  logic [31:0]          req_wdata_i,
  input  logic [15:0]          brg_cmd_i,
  input  logic [BUS_W-1:0]     brg_pri_bus_i,
  input  logic [BUS_W-1:0]     brg_sec_bus_i,
  input  logic [BUS_W-1:0]     brg_sub_bus_i,
  input  logic [15:0]          brg_mem_base_i,
  input  logic [15:0]          brg_mem_limit_i,
  input  logic [15:0]          brg_pf_base_i,
  input  logic [15:0]          brg_pf_limit_i,
  input  logic [NUM_LOCAL-1:0] loc_present_i,
  input  logic [31:0]          tgt_rdata_i,
  output logic [NUM_LOCAL-1:0] loc_sel_o,
  output logic                 fwd_t0_o,
  output logic                 fwd_t1_o,
  output logic                 mem_fwd_o,
  output logic                 miss_o,
  output logic [BUS_W-1:0]     cfg_bus_o,
  output logic [DEV_W-1:0]     cfg_dev_o,
  output logic [FN_W-1:0]      cfg_fn_o,
  output logic [REG_W-1:0]     cfg_reg_o,
  output logic [31:0]          tgt_addr_o,
  output logic                 tgt_write_o,
  output logic [31:0]          tgt_wdata_o,
  output logic                 rsp_valid_o,
  output logic [31:0]          rsp_rdata_o
);
  localparam int LOC_W  = (NUM_LOCAL > 1) ? $clog2(NUM_LOCAL) : 1;
  localparam int NUM_WIN = 2;
  localparam int CMD_MEM = 1;
  localparam int CMD_BM  = 2;

  logic        dec_cfg;
  cfg_fields_t dec_f;

  cfg_addr_decode #(.CFG_NIB(CFG_NIB)) u_dec (
    .addr_i  (req_addr_i),
    .is_cfg_o(dec_cfg),
    .fields_o(dec_f)
  );

  logic rc_pri, rc_ok, rc_sec, rc_below;

  bus_range_check #(.BW(BUS_W)) u_rng (
    .bus_i   (dec_f.bus),
    .pri_i   (brg_pri_bus_i),
    .sec_i   (brg_sec_bus_i),
    .sub_i   (brg_sub_bus_i),
    .is_pri_o(rc_pri),
    .brg_ok_o(rc_ok),
    .is_sec_o(rc_sec),
    .below_o (rc_below)
  );

  logic [15:0]        win_base  [NUM_WIN];
  logic [15:0]        win_limit [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  assign win_base[0]  = brg_mem_base_i;
  assign win_limit[0] = brg_mem_limit_i;
  assign win_base[1]  = brg_pf_base_i;
  assign win_limit[1] = brg_pf_limit_i;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    mem_window_check #(.CMP_LSB(CMP_LSB)) u_win (
      .addr_i (req_addr_i),
      .base_i (win_base[w]),
      .limit_i(win_limit[w]),
      .hit_o  (win_hit[w])
    );
  end

  logic             mem_en;
  logic             loc_in_range;
  logic [LOC_W-1:0] loc_idx;
  logic             loc_hit;
  route_e           route_d;

  assign mem_en       = brg_cmd_i[CMD_MEM] & brg_cmd_i[CMD_BM];
  assign loc_in_range = (32'(dec_f.dev) < NUM_LOCAL);
  assign loc_idx      = dec_f.dev[LOC_W-1:0];
  assign loc_hit      = loc_in_range && (dec_f.fn == '0) && loc_present_i[loc_idx];

  always_comb begin
    route_d = RT_MISS;
    if (dec_cfg) begin
      if (rc_pri)                route_d = loc_hit ? RT_LOCAL : RT_MISS;
      else if (rc_ok && rc_sec)  route_d = RT_T0;
      else if (rc_ok && rc_below) route_d = RT_T1;
    end else if (mem_en && (|win_hit)) begin
      route_d = RT_MEM;
    end
  end

  logic        ready_q;
  logic        accept;
  logic        vld_q;
  route_e      route_q;
  cfg_fields_t f_q;
  logic [31:0] addr_q, wdata_q;
  logic        wr_q;

  assign req_ready_o = ready_q;
  assign accept      = req_valid_i & ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      route_q <= RT_NONE;
      f_q     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= accept;
      if (accept) begin
        route_q <= route_d;
        f_q     <= dec_f;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        wr_q    <= req_write_i;
      end else begin
        route_q <= RT_NONE;
      end
    end
  end

  always_comb begin
    loc_sel_o = '0;
    if (vld_q && route_q == RT_LOCAL) loc_sel_o[f_q.dev[LOC_W-1:0]] = 1'b1;
  end

  assign fwd_t0_o    = vld_q && (route_q == RT_T0);
  assign fwd_t1_o    = vld_q && (route_q == RT_T1);
  assign mem_fwd_o   = vld_q && (route_q == RT_MEM);
  assign miss_o      = vld_q && (route_q == RT_MISS);
  assign cfg_bus_o   = f_q.bus;
  assign cfg_dev_o   = f_q.dev;
  assign cfg_fn_o    = f_q.fn;
  assign cfg_reg_o   = f_q.reg_idx;
  assign tgt_addr_o  = addr_q;
  assign tgt_write_o = wr_q;
  assign tgt_wdata_o = wdata_q;
  assign rsp_valid_o = vld_q;

  always_comb begin
    rsp_rdata_o = '0;
    if (vld_q && !wr_q) rsp_rdata_o = (route_q == RT_MISS) ? '1 : tgt_rdata_i;
  end

  logic [NUM_LOCAL+3:0] route_vec;
  assign route_vec = {loc_sel_o, fwd_t0_o, fwd_t1_o, mem_fwd_o, miss_o};

  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones(route_vec) == 1); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> route_vec == '0); // R9
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o)); // R9
  AST_MISS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !tgt_write_o) |-> rsp_rdata_o == 32'hFFFF_FFFF); // R8
  AST_T0_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_t0_o |-> cfg_bus_o == $past(brg_sec_bus_i)); // R3
  AST_T1_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_t1_o |-> (cfg_bus_o > $past(brg_sec_bus_i)) && (cfg_bus_o <= $past(brg_sub_bus_i))); // R4
  AST_FWD_PROGRAMMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_t0_o || fwd_t1_o) |-> $past(brg_sec_bus_i) > $past(brg_pri_bus_i)); // R5
  AST_MEM_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_fwd_o |-> $past(brg_cmd_i[CMD_MEM] && brg_cmd_i[CMD_BM])); // R7
  AST_MEM_NOT_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_fwd_o |-> tgt_addr_o[31:28] != CFG_NIB); // R1
  AST_LOC_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_sel_o != '0) |-> ((loc_sel_o & $past(loc_present_i)) == loc_sel_o)); // R2
endmodule

// File: tb/cfg_route_top_tb_top.sv
module cfg_route_top_tb_top;
  localparam int NL = 4;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [15:0] cmd = 16'h0006;
  logic [7:0]  pri = 8'd0, sec = 8'd1, sub = 8'd3;
  logic [15:0] mb = 16'h4010, ml = 16'h401F, pb = 16'h4030, pl = 16'h403F;
  logic [NL-1:0] present = 4'b0101;
  logic [31:0] tgt_rdata = 32'hCAFE_0001;

  logic          ready, t0, t1, memf, miss, rv, twr;
  logic [NL-1:0] lsel;
  logic [7:0]    cbus;
  logic [4:0]    cdev;
  logic [2:0]    cfn;
  logic [9:0]    creg;
  logic [31:0]   taddr, twd, rdata;

  cfg_route_top #(.NUM_LOCAL(NL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .brg_cmd_i(cmd), .brg_pri_bus_i(pri), .brg_sec_bus_i(sec), .brg_sub_bus_i(sub),
    .brg_mem_base_i(mb), .brg_mem_limit_i(ml), .brg_pf_base_i(pb), .brg_pf_limit_i(pl),
    .loc_present_i(present), .tgt_rdata_i(tgt_rdata), .loc_sel_o(lsel),
    .fwd_t0_o(t0), .fwd_t1_o(t1), .mem_fwd_o(memf), .miss_o(miss),
    .cfg_bus_o(cbus), .cfg_dev_o(cdev), .cfg_fn_o(cfn), .cfg_reg_o(creg),
    .tgt_addr_o(taddr), .tgt_write_o(twr), .tgt_wdata_o(twd),
    .rsp_valid_o(rv), .rsp_rdata_o(rdata)
  );

  int n_chk = 0, n_bad = 0;

  // codes: 0 miss, 1 local, 2 type-0, 3 type-1, 4 memory
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h3000_0000, 32'h3001_0000, 32'h3000_8000, 32'h3000_1000, 32'h3010_0000,
    32'h3030_0000, 32'h3020_F3FC, 32'h3040_0000, 32'h4010_0000, 32'h401F_FFFC,
    32'h4020_0000, 32'h403F_0000, 32'h400F_FFFC, 32'h2FFF_FFFC, 32'h3020_0004};
  localparam logic       V_WR  [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,1};
  localparam int         V_EXP [NV] = '{1,1,0,0,2, 3,3,0,4,4, 0,4,0,0,3};
  localparam int         V_IDX [NV] = '{0,2,0,0,0, 0,0,0,0,0, 0,0,0,0,0};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int route_code();
    if (lsel != '0) return 1;
    if (t0) return 2;
    if (t1) return 3;
    if (memf) return 4;
    return 0;
  endfunction

  // drive at negedge, accepted on next posedge, sampled at following negedge
  task automatic issue(input logic [31:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = 32'h5A5A_0000 ^ a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic expect_route(input int code, input int idx, input logic w, input string req);
    int rc;
    rc = route_code();
    check(rv == 1'b1, "R9 rsp_valid", 32'(rv), 32'd1);
    check(rc == code, req, 32'(rc), 32'(code));
    if (code == 1) check(lsel == NL'(1 << idx), "R2 loc_sel", 32'(lsel), 32'(1 << idx));
    if (code == 0) begin
      check(miss == 1'b1, "R8 miss", 32'(miss), 32'd1);
      if (!w) check(rdata == 32'hFFFF_FFFF, "R8 miss data", rdata, 32'hFFFF_FFFF);
    end else begin
      check(miss == 1'b0, "R8 no miss on hit", 32'(miss), 32'd0);
      check(rdata == (w ? 32'h0 : tgt_rdata), "R9 rdata", rdata, w ? 32'h0 : tgt_rdata);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R10 ready in reset", 32'(ready), 32'd0);
    check({rv, miss, t0, t1, memf, lsel} == '0, "R10 outputs in reset",
          32'({rv, miss, t0, t1, memf, lsel}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R10 ready after reset", 32'(ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      issue(V_ADDR[i], V_WR[i]);
      expect_route(V_EXP[i], V_IDX[i], V_WR[i], $sformatf("R1 R2 R3 R4 R6 vector %0d route", i));
      if (i == 6) begin
        check(cbus == 8'd2,    "R1 bus field", 32'(cbus), 32'd2);
        check(cdev == 5'd1,    "R1 dev field", 32'(cdev), 32'd1);
        check(cfn  == 3'd7,    "R1 fn field",  32'(cfn),  32'd7);
        check(creg == 10'hFF,  "R1 reg field", 32'(creg), 32'hFF);
      end
      if (i == 2) begin
        idle();
        check(miss == 1'b0 && rv == 1'b0, "R8 miss one cycle", 32'({miss, rv}), 32'd0);
      end
      idle();
    end

    // R6 low nibble of base/limit ignored
    mb = 16'h401F; ml = 16'h4010;
    issue(32'h4010_0000, 1'b0);
    expect_route(4, 0, 1'b0, "R6 nibble ignored");
    idle();
    mb = 16'h4010; ml = 16'h401F;

    // R7 memory enable requires both command bits
    cmd = 16'h0002;
    issue(32'h4010_0000, 1'b0);
    expect_route(0, 0, 1'b0, "R7 mem only");
    idle();
    cmd = 16'h0004;
    issue(32'h4030_0000, 1'b0);
    expect_route(0, 0, 1'b0, "R7 master only");
    idle();
    cmd = 16'h0006;

    // R5 unprogrammed bridge
    sec = 8'd0; sub = 8'd0;
    issue(32'h3010_0000, 1'b0);
    expect_route(0, 0, 1'b0, "R5 unnumbered bridge");
    idle();
    sec = 8'd2; sub = 8'd1;
    issue(32'h3020_0000, 1'b0);
    expect_route(0, 0, 1'b0, "R5 sub below sec");
    idle();
    sec = 8'd1; sub = 8'd3;

    // R3 with non-zero primary: primary bus local, bus equal sec type-0
    pri = 8'd4; sec = 8'd5; sub = 8'd5;
    issue(32'h3050_0000, 1'b0);
    expect_route(2, 0, 1'b0, "R3 moved buses");
    idle();
    issue(32'h3040_0000, 1'b0);
    expect_route(1, 0, 1'b0, "R2 primary not zero");
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule